// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block is the refresh scheduler inside an SDRAM controller. A free-running interval timer sets the refresh rate: one AUTO REFRESH is owed every `INTERVAL` cycles, with `INTERVAL = CLK_MHZ*1000*WINDOW_MS/REF_ROWS` rounded down, so that `REF_ROWS` refreshes fit in each `WINDOW_MS` window. Refreshes that are owed but not yet issued build up in a small debt counter. While debt is outstanding the block raises `ref_req` to the command arbiter. A grant causes one AUTO REFRESH, and the block then holds `busy` for the row-cycle time. When the debt reaches its ceiling, `ref_urgent` tells the arbiter to close its banks and grant at once.

The handshake works like valid/ready. `ref_req` plays the part of valid and `ref_gnt` plays the part of ready. A transfer takes place on a clock edge where both are high. The arbiter grants only while all banks are idle and the command bus is free. A grant sampled while `ref_req` is low is ignored. The block never drops `ref_req` on its own before a transfer, except that `sr_req` changes what the transfer means. If `sr_req` is high at the transfer, the refresh command goes out with CKE low and the device enters self refresh.

Self refresh lasts at least `T_RAS` cycles. After that, the block waits for `sr_req` to fall and then raises CKE. It sends guard NOPs for `max(T_XSR, T_RC, 2)` cycles and then, with no grant, issues `CATCHUP` back-to-back refreshes, one every `T_RC` cycles. This rebuilds the row coverage, because the device's internal row pointer is unknown after self refresh.

Top module: `sdram_refresh_sequencer`

## Requirements
- R1: With no grant, the first `ref_req` appears `INTERVAL` cycles after reset release, and the debt grows by one every `INTERVAL` cycles. The timer is held at zero from self-refresh entry until the catch-up burst has finished.
- R2: A refresh command is CS=0, RAS=0, CAS=0, WE=0 inverted, written as {cs_n,ras_n,cas_n,we_n}=0001. Every other cycle carries NOP, 0111. A granted refresh appears in the cycle after the grant edge and lasts exactly one cycle.
- R3: `busy` is high from a refresh cycle through the following `T_RC-1` cycles. Two refresh commands are never closer than `T_RC` cycles.
- R4: The debt saturates at `MAX_POSTPONE`. `ref_urgent` is high exactly while the debt is at that limit. Each granted ordinary refresh lowers the debt by one. `ref_req` is high while the block is idle and either debt is nonzero or `sr_req` is high.
- R5: A grant sampled while `ref_req` is low has no effect: the next cycle still shows NOP with CKE high.
- R6: A transfer while `sr_req` is high emits the refresh encoding with `cke` low in the same cycle, which is the self-refresh entry, and clears the debt.
- R7: `cke` stays low for at least `T_RAS` cycles, even if `sr_req` falls earlier.
- R8: Once self refresh may end and `sr_req` is sampled low, `cke` rises with NOP. Exactly `max(T_XSR,T_RC,2)` NOP cycles, the rise cycle included, come before the first catch-up refresh.
- R9: Exactly `CATCHUP` catch-up refreshes follow, spaced `T_RC` cycles apart, with no grant needed. Then `busy` falls.
- R10: `busy` is high in every non-idle phase, self refresh included, and `ref_req` is low whenever `busy` is high.
- R11: During reset the outputs are: `cke` high, NOP, `busy`, `ref_req` and `ref_urgent` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_req | input | 1 | Power management asks for self refresh (level) |
| ref_gnt | input | 1 | Arbiter grant; banks idle and bus free |
| ref_req | output | 1 | Refresh or self-refresh entry wanted |
| ref_urgent | output | 1 | Debt at ceiling, grant must come now |
| busy | output | 1 | Arbiter must hold off every command |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The assertions assume the arbiter grants only while all banks are idle. They also assume the arbiter issues nothing of its own while `busy` is high, so that every refresh-encoded cycle on the pins comes from this block. The stimulus drives only `ref_gnt` and `sr_req`. It holds the grant off long enough to saturate the debt, keeps it high so that requests are taken at once, and drops `sr_req` both before and long after the minimum self-refresh time. All input changes happen just after a clock edge.

// File: rtl/sref_pkg.sv
package sref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRC,
    ST_SR_MIN,
    ST_SR_HOLD,
    ST_EXIT
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] count_q;

  assign tick = run && (count_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      count_q <= '0;
    end else if (count_q == LAST) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  input  logic clear,
  output logic nonzero,
  output logic full
);
  localparam int DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] TOP = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q;

  assign nonzero = (debt_q != '0);
  assign full    = (debt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      debt_q <= '0;
    end else begin
      case ({tick, take})
        2'b10:   if (debt_q != TOP) debt_q <= debt_q + 1'b1;
        2'b01:   if (debt_q != '0) debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end
endmodule

// File: rtl/refresh_seq_fsm.sv
module refresh_seq_fsm
  import sref_pkg::*;
#(
  parameter int T_RC    = 7,
  parameter int T_RAS   = 5,
  parameter int T_XSR   = 8,
  parameter int CATCHUP = 4096
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    want_ref,
  input  logic    sr_req,
  input  logic    gnt,
  output logic    take,
  output logic    clear,
  output logic    seq_active,
  output logic    ref_req,
  output logic    busy,
  output sd_cmd_t cmd,
  output logic    cke
);
  localparam int XSR_A   = (T_XSR > T_RC) ? T_XSR : T_RC;
  localparam int XSR_EFF = (XSR_A > 2) ? XSR_A : 2;
  localparam int CMAX_A  = (XSR_EFF > T_RAS) ? XSR_EFF : T_RAS;
  localparam int CW      = $clog2(CMAX_A + 1);
  localparam int LW      = $clog2(CATCHUP + 1);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] left_q;
  sd_cmd_t       cmd_q;
  logic          cke_q;
  logic          seq_q;
  logic          xfer;

  assign ref_req    = (state_q == ST_IDLE) && (want_ref || sr_req);
  assign busy       = (state_q != ST_IDLE);
  assign xfer       = ref_req && gnt;
  assign take       = xfer && !sr_req;
  assign clear      = xfer && sr_req;
  assign seq_active = seq_q;
  assign cmd        = cmd_q;
  assign cke        = cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      cmd_q   <= CMD_NOP;
      cke_q   <= 1'b1;
      seq_q   <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      case (state_q)
        ST_IDLE: begin
          if (xfer) begin
            cmd_q <= CMD_AREF;
            if (sr_req) begin
              cke_q   <= 1'b0;
              seq_q   <= 1'b1;
              cnt_q   <= CW'(T_RAS - 1);
              state_q <= ST_SR_MIN;
            end else begin
              cnt_q   <= CW'(T_RC - 1);
              left_q  <= '0;
              state_q <= ST_TRC;
            end
          end
        end
        ST_TRC: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (left_q == '0) begin
            seq_q   <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            cmd_q  <= CMD_AREF;
            cnt_q  <= CW'(T_RC - 1);
            left_q <= left_q - 1'b1;
          end
        end
        ST_SR_MIN: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else             state_q <= ST_SR_HOLD;
        end
        ST_SR_HOLD: begin
          if (!sr_req) begin
            cke_q   <= 1'b1;
            cnt_q   <= CW'(XSR_EFF - 1);
            state_q <= ST_EXIT;
          end
        end
        ST_EXIT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            cmd_q   <= CMD_AREF;
            cnt_q   <= CW'(T_RC - 1);
            left_q  <= LW'(CATCHUP - 1);
            state_q <= ST_TRC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_sequencer.sv
module sdram_refresh_sequencer
  import sref_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int WINDOW_MS    = 64,
  parameter int REF_ROWS     = 4096,
  parameter int T_RC         = 7,
  parameter int T_RAS        = 5,
  parameter int T_XSR        = 8,
  parameter int MAX_POSTPONE = 8,
  parameter int CATCHUP      = REF_ROWS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_req,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic busy,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int RAW_INTERVAL = (CLK_MHZ * 1000 * WINDOW_MS) / REF_ROWS;
  localparam int INTERVAL     = (RAW_INTERVAL > 2) ? RAW_INTERVAL : 2;

  logic    tick, take, clear, seq_active, owed;
  sd_cmd_t cmd;

  refresh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!seq_active),
    .tick (tick)
  );

  refresh_debt_counter #(.MAX_DEBT(MAX_POSTPONE)) u_debt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .take   (take),
    .clear  (clear),
    .nonzero(owed),
    .full   (ref_urgent)
  );

  refresh_seq_fsm #(
    .T_RC   (T_RC),
    .T_RAS  (T_RAS),
    .T_XSR  (T_XSR),
    .CATCHUP(CATCHUP)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_ref  (owed),
    .sr_req    (sr_req),
    .gnt       (ref_gnt),
    .take      (take),
    .clear     (clear),
    .seq_active(seq_active),
    .ref_req   (ref_req),
    .busy      (busy),
    .cmd       (cmd),
    .cke       (cke)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
endmodule

// File: rtl/sdram_refresh_sequencer_chk.sv
module sdram_refresh_sequencer_chk #(
  parameter int T_RC  = 7,
  parameter int T_XSR = 8
) (
  input logic clk,
  input logic rst_n,
  input logic sr_req,
  input logic ref_gnt,
  input logic ref_req,
  input logic ref_urgent,
  input logic busy,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  localparam int XSR_A   = (T_XSR > T_RC) ? T_XSR : T_RC;
  localparam int XSR_EFF = (XSR_A > 2) ? XSR_A : 2;

  logic aref, nop, cke_d, rise;
  int   since_aref, since_rise;

  assign aref = !cs_n && !ras_n && !cas_n && we_n;
  assign nop  = !cs_n && ras_n && cas_n && we_n;
  assign rise = cke && !cke_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_d      <= 1'b1;
      since_aref <= T_RC;
      since_rise <= XSR_EFF;
    end else begin
      cke_d <= cke;
      if (aref)                  since_aref <= 1;
      else if (since_aref < T_RC) since_aref <= since_aref + 1;
      if (rise)                      since_rise <= 1;
      else if (since_rise < XSR_EFF) since_rise <= since_rise + 1;
    end
  end

  // R2: a refresh command lasts one cycle
  a_r2_aref_single: assert property (@(posedge clk) disable iff (!rst_n)
    aref |=> !aref);

  // R3: refresh spacing and busy cover
  a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    aref |-> since_aref >= T_RC);
  a_r3_busy_on_aref: assert property (@(posedge clk) disable iff (!rst_n)
    aref |-> busy);

  // R4: urgency implies a pending request or work in progress
  a_r4_urgent_req: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> (ref_req || busy));

  // R5: stray grant is ignored
  a_r5_stray_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ref_gnt && !ref_req) |=> (nop && cke));

  // R6: CKE falls only with the refresh encoding
  a_r6_entry_enc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> aref);

  // R8: CKE rises with NOP, and the guard window is respected
  a_r8_rise_nop: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> nop);
  a_r8_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (aref && cke) |-> since_rise >= XSR_EFF);

  // R10: no request while busy
  a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ref_req);
  a_r10_sr_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy);
endmodule

bind sdram_refresh_sequencer sdram_refresh_sequencer_chk #(
  .T_RC (T_RC),
  .T_XSR(T_XSR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sr_req    (sr_req),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .ref_urgent(ref_urgent),
  .busy      (busy),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n)
);

// File: tb/sim_sdram_refresh_sequencer.sv
`timescale 1ns/1ps
module sim_sdram_refresh_sequencer;
  localparam int CLK_MHZ = 1, WINDOW_MS = 64, REF_ROWS = 4096;
  localparam int T_RC = 4, T_RAS = 5, T_XSR = 7, MAXP = 8, CATCH = 6;
  localparam int INTERVAL = 15;
  localparam int XSR_EFF  = 7;

  logic clk = 1'b0, rst_n = 1'b0, sr_req = 1'b0, ref_gnt = 1'b0;
  logic ref_req, ref_urgent, busy, cke, cs_n, ras_n, cas_n, we_n;

  always #5 clk = ~clk;

  sdram_refresh_sequencer #(
    .CLK_MHZ(CLK_MHZ), .WINDOW_MS(WINDOW_MS), .REF_ROWS(REF_ROWS),
    .T_RC(T_RC), .T_RAS(T_RAS), .T_XSR(T_XSR),
    .MAX_POSTPONE(MAXP), .CATCHUP(CATCH)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .busy(busy), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model; phase 0 idle,1 rc wait,2 sr min,3 sr hold,4 exit
  int m_tmr, m_pend, m_ph, m_cnt, m_left, m_cke, m_aref, m_seq;
  int o_req, t_tick;
  bit prev_stray;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tmr = 0; m_pend = 0; m_ph = 0; m_cnt = 0; m_left = 0;
      m_cke = 1; m_aref = 0; m_seq = 0; prev_stray = 0;
    end else begin
      o_req = (m_ph == 0 && (m_pend > 0 || sr_req)) ? 1 : 0;
      prev_stray = (m_ph == 0) && ref_gnt && !o_req;
      t_tick = (!m_seq && m_tmr == INTERVAL - 1) ? 1 : 0;
      if (m_seq != 0 || m_tmr == INTERVAL - 1) m_tmr = 0; else m_tmr++;
      m_aref = 0;
      case (m_ph)
        0: if (o_req && ref_gnt) begin
             m_aref = 1;
             if (sr_req) begin
               m_cke = 0; m_seq = 1; m_cnt = T_RAS - 1; m_ph = 2; m_pend = 0; t_tick = 0;
             end else begin
               m_cnt = T_RC - 1; m_left = 0; m_ph = 1; m_pend--;
             end
           end
        1: if (m_cnt > 0) m_cnt--;
           else if (m_left == 0) begin m_ph = 0; m_seq = 0; end
           else begin m_aref = 1; m_cnt = T_RC - 1; m_left--; end
        2: if (m_cnt > 0) m_cnt--; else m_ph = 3;
        3: if (!sr_req) begin m_cke = 1; m_cnt = XSR_EFF - 1; m_ph = 4; end
        4: if (m_cnt > 0) m_cnt--;
           else begin m_aref = 1; m_cnt = T_RC - 1; m_left = CATCH - 1; m_ph = 1; end
        default: m_ph = 0;
      endcase
      if (t_tick != 0) m_pend = (m_pend < MAXP) ? m_pend + 1 : MAXP;
    end
  end

  // Per-cycle comparison plus event-based checks
  int cyc = 0, last_aref = -1000, fall_cyc = 0, rise_cyc = 0, n_catch = 0, sr_done = 0;
  bit in_catch = 0, cke_prev = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      logic is_aref;
      cyc++;
      is_aref = !cs_n && !ras_n && !cas_n && we_n;
      chk(prev_stray ? "R5" : "R2", {cs_n, ras_n, cas_n, we_n},
          m_aref ? 4'b0001 : 4'b0111);
      chk("R6", cke, m_cke);
      chk("R10", busy, (m_ph != 0) ? 1 : 0);
      chk("R4 req", ref_req, (m_ph == 0 && (m_pend > 0 || sr_req)) ? 1 : 0);
      chk("R4 urgent", ref_urgent, (m_pend == MAXP) ? 1 : 0);
      if (cyc < INTERVAL) chk("R1", ref_req, 0);
      if (is_aref) begin
        if (cyc - last_aref < T_RC) chk("R3 spacing", cyc - last_aref, T_RC);
        else checks++;
        last_aref = cyc;
      end
      if (!cke && cke_prev) begin
        fall_cyc = cyc;
        chk("R6 entry", is_aref, 1);
      end
      if (cke && !cke_prev) begin
        rise_cyc = cyc;
        if (cyc - fall_cyc < T_RAS) chk("R7", cyc - fall_cyc, T_RAS);
        else checks++;
        in_catch = 1; n_catch = 0;
      end
      if (in_catch && is_aref) begin
        if (n_catch == 0) chk("R8 guard", cyc - rise_cyc, XSR_EFF);
        n_catch++;
      end
      if (in_catch && !busy) begin
        chk("R9 count", n_catch, CATCH);
        in_catch = 0; sr_done++;
      end
      cke_prev = cke;
    end else begin
      chk("R11 cke", cke, 1);
      chk("R11 cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      chk("R11 flags", {busy, ref_req, ref_urgent}, 0);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  bit finished = 0;

  initial begin
    cycles(4);
    rst_n = 1'b1;
    cycles(140);                  // R4: debt saturates with no grant
    chk("R4 saturate", ref_urgent, 1);
    ref_gnt = 1'b1;
    cycles(120);                  // drain, then serve each tick
    sr_req = 1'b1;                // R6/R7: enter, release early
    cycles(3);
    sr_req = 1'b0;
    cycles(60);
    sr_req = 1'b1;                // long self refresh
    cycles(40);
    sr_req = 1'b0;
    cycles(60);
    ref_gnt = 1'b0;
    cycles(50);
    ref_gnt = 1'b1;
    cycles(30);
    chk("R9 sequences", sr_done, 2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule